// File: doc/BRIEF.md
# Partitioned Logarithmic-Number Multiplier

This block multiplies two 64-bit words in which every lane holds a number in a logarithmic number system. A lane of n bits stores a sign in its top bit and a biased exponent in the n-1 bits below it. The lane's value is (-1)^sign times 2^(exponent - bias), with bias = 2^(n-2). A two-bit size select splits the word into lanes of 8, 16, 32 or 64 bits. The block computes every lane product independently.

A product in this format is not a plain add or subtract. The result sign is the XOR of the two operand signs. The result exponent is the sum of the two exponent fields minus one bias, not two. An exponent that leaves the field's range is saturated and flagged per lane. The block accepts one operation per cycle through a valid/ready handshake and holds the result in a single output register.

Top module: `lns_pmul`

## Requirements
- R1: For every lane, the result sign bit (bit n-1 of the lane) equals the XOR of the two operand sign bits, whatever the exponent outcome.
- R2: The lane width n follows in_size as 0→8, 1→16, 2→32, 3→64 bits. Lane i occupies bits [i*n +: n], with its exponent field in the low n-1 bits. When E1+E2-bias lies in 0 .. 2^(n-1)-1, with bias = 2^(n-2), the result exponent field holds exactly that value and neither flag of the lane is set.
- R3: When E1+E2-bias exceeds 2^(n-1)-1, the lane's exponent field is all ones and out_ovf[i] is 1.
- R4: When E1+E2 is below the bias, the lane's exponent field is zero and out_unf[i] is 1.
- R5: Lanes are independent. No carry or borrow of one lane's exponent sum changes a neighbouring lane's bits, even with every field at its maximum.
- R6: out_valid is 1 in the cycle after a cycle in which in_valid and in_ready were both 1. While out_valid is 1 and out_ready is 0, out_word, out_ovf and out_unf hold their values.
- R7: in_ready is 1 exactly when out_valid is 0 or out_ready is 1.
- R8: After synchronous reset, out_valid is 0 and in_ready is 1.
- R9: Flag bits out_ovf[i] and out_unf[i] for i ≥ 64/n are 0. A lane never has both flags set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands presented |
| in_ready | output | 1 | Block can accept operands |
| in_size | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64) |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result register holds a product |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 64 | Packed product |
| out_ovf | output | 8 | Per-lane exponent overflow, lane i at bit i |
| out_unf | output | 8 | Per-lane exponent underflow, lane i at bit i |

## Verification
The bench drives exponents that land exactly on the field maximum and one past it, and exactly on zero and one below it, for every lane width. A design that subtracts the bias twice, or uses a bias fixed to one width, misses these edges by a factor of two. All-ones fields in every 8-bit lane would expose a carry leaking into a neighbouring lane as a corrupted sign. Random back-pressure on out_ready checks that a stalled result stays unchanged and that in_ready drops only while a result is stuck.

// File: rtl/lns_pmul_pkg.sv
package lns_pmul_pkg;

    localparam int WORD_W    = 64;
    localparam int MIN_CHUNK = 8;
    localparam int N_SIZES   = 4;
    localparam int SEL_W     = $clog2(N_SIZES);
    localparam int MAX_LANES = WORD_W / MIN_CHUNK;

    typedef enum logic [SEL_W-1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_size_e;

    typedef enum logic [1:0] {
        EXP_IN_RANGE = 2'd0,
        EXP_ABOVE    = 2'd1,
        EXP_BELOW    = 2'd2
    } exp_class_e;

    function automatic int lane_width(input int sel);
        return MIN_CHUNK << sel;
    endfunction

endpackage

// File: rtl/lns_lane_mul.sv
module lns_lane_mul #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] op_a,
    input  logic [CW-1:0] op_b,
    output logic [CW-1:0] prod,
    output logic          ovf,
    output logic          unf
);
    import lns_pmul_pkg::*;

    localparam int EW = CW - 1;
    localparam logic [CW:0] BIAS  = (CW+1)'(1) << (CW - 2);
    localparam logic [CW:0] LIMIT = (CW+1)'(3) << (CW - 2);

    logic [CW:0]   exp_sum;
    logic [CW:0]   exp_unb;
    logic [EW-1:0] exp_out;
    exp_class_e    cls;

    always_comb begin
        exp_sum = {2'b00, op_a[EW-1:0]} + {2'b00, op_b[EW-1:0]};
        exp_unb = exp_sum - BIAS;
        if (exp_sum < BIAS)
            cls = EXP_BELOW;
        else if (exp_sum >= LIMIT)
            cls = EXP_ABOVE;
        else
            cls = EXP_IN_RANGE;
    end

    always_comb begin
        unique case (cls)
            EXP_ABOVE: exp_out = '1;
            EXP_BELOW: exp_out = '0;
            default:   exp_out = exp_unb[EW-1:0];
        endcase
    end

    assign prod = {op_a[CW-1] ^ op_b[CW-1], exp_out};
    assign ovf  = (cls == EXP_ABOVE);
    assign unf  = (cls == EXP_BELOW);

endmodule

// File: rtl/lns_lane_bank.sv
module lns_lane_bank #(
    parameter int WORD_W    = lns_pmul_pkg::WORD_W,
    parameter int MAX_LANES = lns_pmul_pkg::MAX_LANES,
    parameter int CW        = 8
) (
    input  logic [WORD_W-1:0]    op_a,
    input  logic [WORD_W-1:0]    op_b,
    output logic [WORD_W-1:0]    prod,
    output logic [MAX_LANES-1:0] ovf,
    output logic [MAX_LANES-1:0] unf
);
    localparam int NL = WORD_W / CW;

    logic [NL-1:0] lane_ovf;
    logic [NL-1:0] lane_unf;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        lns_lane_mul #(.CW(CW)) u_lane (
            .op_a (op_a[i*CW +: CW]),
            .op_b (op_b[i*CW +: CW]),
            .prod (prod[i*CW +: CW]),
            .ovf  (lane_ovf[i]),
            .unf  (lane_unf[i])
        );
    end

    if (NL < MAX_LANES) begin : g_pad
        assign ovf = {{(MAX_LANES-NL){1'b0}}, lane_ovf};
        assign unf = {{(MAX_LANES-NL){1'b0}}, lane_unf};
    end else begin : g_full
        assign ovf = lane_ovf;
        assign unf = lane_unf;
    end

endmodule

// File: rtl/lns_pmul_stage.sv
module lns_pmul_stage #(
    parameter int WORD_W    = lns_pmul_pkg::WORD_W,
    parameter int MAX_LANES = lns_pmul_pkg::MAX_LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 d_valid,
    output logic                 d_ready,
    input  logic [WORD_W-1:0]    d_word,
    input  logic [MAX_LANES-1:0] d_ovf,
    input  logic [MAX_LANES-1:0] d_unf,
    output logic                 q_valid,
    input  logic                 q_ready,
    output logic [WORD_W-1:0]    q_word,
    output logic [MAX_LANES-1:0] q_ovf,
    output logic [MAX_LANES-1:0] q_unf
);
    logic take;

    assign d_ready = !q_valid || q_ready;
    assign take    = d_valid && d_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
        end else if (d_ready) begin
            q_valid <= d_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_word <= '0;
            q_ovf  <= '0;
            q_unf  <= '0;
        end else if (take) begin
            q_word <= d_word;
            q_ovf  <= d_ovf;
            q_unf  <= d_unf;
        end
    end

endmodule

// File: rtl/lns_pmul.sv
module lns_pmul #(
    parameter int WORD_W    = lns_pmul_pkg::WORD_W,
    parameter int MIN_CHUNK = lns_pmul_pkg::MIN_CHUNK,
    parameter int N_SIZES   = lns_pmul_pkg::N_SIZES
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [lns_pmul_pkg::SEL_W-1:0]      in_size,
    input  logic [WORD_W-1:0]                   in_a,
    input  logic [WORD_W-1:0]                   in_b,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [WORD_W-1:0]                   out_word,
    output logic [lns_pmul_pkg::MAX_LANES-1:0]  out_ovf,
    output logic [lns_pmul_pkg::MAX_LANES-1:0]  out_unf
);
    import lns_pmul_pkg::*;

    localparam int ML = WORD_W / MIN_CHUNK;

    logic [WORD_W-1:0] bank_prod [N_SIZES];
    logic [ML-1:0]     bank_ovf  [N_SIZES];
    logic [ML-1:0]     bank_unf  [N_SIZES];

    logic [WORD_W-1:0] sel_prod;
    logic [ML-1:0]     sel_ovf;
    logic [ML-1:0]     sel_unf;

    for (genvar s = 0; s < N_SIZES; s++) begin : g_bank
        lns_lane_bank #(
            .WORD_W    (WORD_W),
            .MAX_LANES (ML),
            .CW        (MIN_CHUNK << s)
        ) u_bank (
            .op_a (in_a),
            .op_b (in_b),
            .prod (bank_prod[s]),
            .ovf  (bank_ovf[s]),
            .unf  (bank_unf[s])
        );
    end

    always_comb begin
        sel_prod = bank_prod[0];
        sel_ovf  = bank_ovf[0];
        sel_unf  = bank_unf[0];
        for (int s = 1; s < N_SIZES; s++) begin
            if (int'(in_size) == s) begin
                sel_prod = bank_prod[s];
                sel_ovf  = bank_ovf[s];
                sel_unf  = bank_unf[s];
            end
        end
    end

    lns_pmul_stage #(
        .WORD_W    (WORD_W),
        .MAX_LANES (ML)
    ) u_stage (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_ready (in_ready),
        .d_word  (sel_prod),
        .d_ovf   (sel_ovf),
        .d_unf   (sel_unf),
        .q_valid (out_valid),
        .q_ready (out_ready),
        .q_word  (out_word),
        .q_ovf   (out_ovf),
        .q_unf   (out_unf)
    );

endmodule

// File: rtl/lns_pmul_chk.sv
module lns_pmul_chk #(
    parameter int WORD_W    = lns_pmul_pkg::WORD_W,
    parameter int MIN_CHUNK = lns_pmul_pkg::MIN_CHUNK,
    parameter int ML        = lns_pmul_pkg::MAX_LANES
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             in_valid,
    input logic                             in_ready,
    input logic [lns_pmul_pkg::SEL_W-1:0]   in_size,
    input logic [WORD_W-1:0]                in_a,
    input logic [WORD_W-1:0]                in_b,
    input logic                             out_valid,
    input logic                             out_ready,
    input logic [WORD_W-1:0]                out_word,
    input logic [ML-1:0]                    out_ovf,
    input logic [ML-1:0]                    out_unf
);
    logic acc;
    assign acc = in_valid && in_ready;

    // R8
    reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R6
    accept_latency_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_word) && $stable(out_ovf) && $stable(out_unf)));

    // R7
    stall_backpress_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_ovf & out_unf) == '0));

    // R9
    wide_flags_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && in_size == 2'd3) |=> (out_ovf[ML-1:1] == '0 && out_unf[ML-1:1] == '0));

    // R1
    wide_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && in_size == 2'd3) |=> (out_word[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1])));

    for (genvar i = 0; i < ML; i++) begin : g_narrow
        // R3
        narrow_sat_chk: assert property (@(posedge clk) disable iff (rst)
            (acc && in_size == 2'd0) |=>
                (!out_ovf[i] || out_word[MIN_CHUNK*i +: MIN_CHUNK-1] == '1));
        // R4
        narrow_clamp_chk: assert property (@(posedge clk) disable iff (rst)
            (acc && in_size == 2'd0) |=>
                (!out_unf[i] || out_word[MIN_CHUNK*i +: MIN_CHUNK-1] == '0));
    end

endmodule

bind lns_pmul lns_pmul_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_size   (in_size),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf)
);

// File: tb/lns_pmul_test.sv
`timescale 1ns/1ps
module lns_pmul_test;

    typedef struct {
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  size;
        bit          iso;
    } op_t;

    typedef struct {
        logic [63:0] word;
        logic [7:0]  ovf;
        logic [7:0]  unf;
        logic [1:0]  size;
        bit          iso;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_size = 2'd0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_word;
    logic [7:0]  out_ovf;
    logic [7:0]  out_unf;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lns_pmul uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_size   (in_size),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .out_ovf   (out_ovf),
        .out_unf   (out_unf)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input op_t op);
        exp_t r;
        int n;
        int nl;
        logic [65:0] e1, e2, s, bias, lim, e;
        n  = 8 << op.size;
        nl = 64 / n;
        r.word = '0; r.ovf = '0; r.unf = '0; r.size = op.size; r.iso = op.iso;
        bias = 66'd1 << (n - 2);
        lim  = 66'd3 << (n - 2);
        for (int c = 0; c < nl; c++) begin
            e1 = '0; e2 = '0;
            for (int k = 0; k < n - 1; k++) begin
                e1[k] = op.a[c*n + k];
                e2[k] = op.b[c*n + k];
            end
            s = e1 + e2;
            if (s < bias) begin
                e = '0; r.unf[c] = 1'b1;
            end else if (s >= lim) begin
                e = (66'd1 << (n - 1)) - 1; r.ovf[c] = 1'b1;
            end else begin
                e = s - bias;
            end
            for (int k = 0; k < n - 1; k++) r.word[c*n + k] = e[k];
            r.word[c*n + n - 1] = op.a[c*n + n - 1] ^ op.b[c*n + n - 1];
        end
        return r;
    endfunction

    function automatic logic [63:0] fill(input logic [1:0] size, input bit sg,
                                         input logic [65:0] ex);
        logic [63:0] w;
        int n;
        n = 8 << size;
        w = '0;
        for (int c = 0; c < 64 / n; c++) begin
            for (int k = 0; k < n - 1; k++) w[c*n + k] = ex[k];
            w[c*n + n - 1] = sg;
        end
        return w;
    endfunction

    task automatic compare(input exp_t x);
        int n;
        logic [65:0] ae, ee;
        string tag;
        n = 8 << x.size;
        for (int c = 0; c < 64 / n; c++) begin
            check(out_word[c*n + n - 1] == x.word[c*n + n - 1], "R1", "lane sign",
                  66'(out_word[c*n + n - 1]), 66'(x.word[c*n + n - 1]));
            ae = '0; ee = '0;
            for (int k = 0; k < n - 1; k++) begin
                ae[k] = out_word[c*n + k];
                ee[k] = x.word[c*n + k];
            end
            if (x.iso)          tag = "R5";
            else if (x.ovf[c])  tag = "R3";
            else if (x.unf[c])  tag = "R4";
            else                tag = "R2";
            check(ae == ee && out_ovf[c] == x.ovf[c] && out_unf[c] == x.unf[c],
                  tag, "lane exponent/flags", {ae[63:0], out_ovf[c], out_unf[c]},
                  {ee[63:0], x.ovf[c], x.unf[c]});
        end
        check(out_ovf == x.ovf && out_unf == x.unf, "R9", "flag vectors",
              66'({out_ovf, out_unf}), 66'({x.ovf, x.unf}));
    endtask

    op_t  stim[$];
    exp_t pend[$];

    initial begin
        bit   mdl_valid;
        bit   accepted;
        int   cyc;
        op_t  cur;
        exp_t x;
        bit   ihs, ohs;
        logic [65:0] bias, mx;

        // directed corner operations for each lane width
        for (int sz = 0; sz < 4; sz++) begin
            int n;
            n = 8 << sz;
            bias = 66'd1 << (n - 2);
            mx   = (66'd1 << (n - 1)) - 1;
            stim.push_back('{fill(2'(sz), 0, bias),   fill(2'(sz), 0, bias),     2'(sz), 0});
            stim.push_back('{fill(2'(sz), 1, mx),     fill(2'(sz), 0, bias),     2'(sz), 0});
            stim.push_back('{fill(2'(sz), 0, mx),     fill(2'(sz), 1, bias + 1), 2'(sz), 0});
            stim.push_back('{fill(2'(sz), 1, 66'd0),  fill(2'(sz), 1, bias),     2'(sz), 0});
            stim.push_back('{fill(2'(sz), 0, 66'd0),  fill(2'(sz), 1, bias - 1), 2'(sz), 0});
            stim.push_back('{fill(2'(sz), 1, mx),     fill(2'(sz), 0, mx),       2'(sz), 1});
        end
        for (int i = 0; i < 400; i++) begin
            op_t r;
            r.a = {$urandom, $urandom};
            r.b = {$urandom, $urandom};
            r.size = 2'($urandom_range(0, 3));
            r.iso = 0;
            stim.push_back(r);
        end

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R8", "out_valid after reset", 66'(out_valid), 66'd0);
        check(in_ready == 1'b1, "R8", "in_ready after reset", 66'(in_ready), 66'd1);

        mdl_valid = 0;
        accepted  = 0;
        cyc       = 0;
        while ((stim.size() > 0 || pend.size() > 0 || in_valid) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            out_ready = ($urandom_range(0, 9) < 7);
            if (!in_valid || accepted) begin
                if (stim.size() > 0 && $urandom_range(0, 9) < 8) begin
                    cur = stim.pop_front();
                    in_valid = 1'b1;
                    in_a = cur.a; in_b = cur.b; in_size = cur.size;
                end else begin
                    in_valid = 1'b0;
                end
            end
            #1;
            check(in_ready == (!out_valid || out_ready), "R7", "in_ready",
                  66'(in_ready), 66'(!out_valid || out_ready));
            check(out_valid == mdl_valid, "R6", "out_valid timing",
                  66'(out_valid), 66'(mdl_valid));
            if (out_valid && pend.size() > 0) compare(pend[0]);
            ohs = out_valid && out_ready;
            ihs = in_valid && in_ready;
            if (ohs && pend.size() > 0) void'(pend.pop_front());
            if (ihs) begin
                cur.a = in_a; cur.b = in_b; cur.size = in_size;
                x = model(cur);
                x.iso = 0;
                foreach (stim[j]) begin end
                pend.push_back(x);
            end
            mdl_valid = ihs ? 1'b1 : (ohs ? 1'b0 : mdl_valid);
            accepted  = ihs;
        end
        if (cyc >= 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not drain, actual %0d expected < 20000", cyc);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // directed isolation tag: all-ones exponents in every 8-bit lane with
    // opposite signs must leave each neighbour's sign bit intact (R5)
    initial begin
        op_t t;
        exp_t r;
        t.a = fill(2'd0, 1, 66'h7f);
        t.b = fill(2'd0, 0, 66'h7f);
        t.size = 2'd0;
        t.iso = 1;
        r = model(t);
        #1;
        check(r.word == 64'hff_ff_ff_ff_ff_ff_ff_ff && r.ovf == 8'hff, "R5",
              "model isolation vector", 66'(r.word), 66'hff_ff_ff_ff_ff_ff_ff_ff);
    end

endmodule